// File: doc/BRIEF.md
# Modular Signed-Digit Multiplier

This block multiplies two residues modulo `m = 2^N + MU`, where `MU` is one of -1, 0 or +1. Both operands and the product are N-digit radix-2 signed-digit vectors. Each digit takes two bits: the upper bit is the sign and the lower bit is the magnitude. Because the representation is redundant, the product is a congruent value and is not a normalized remainder. A consumer that needs a canonical residue performs that conversion downstream.

There are N partial products, one for each digit of `y`. Partial product i is `x` rotated up by i digit places. The digits that leave the top come back in at the bottom, multiplied by `-MU`. The rotation is plain wiring. The multiplier digit `y_i` then passes the rotated word unchanged, negates it, or clears it. A binary tree of carry-free modular signed-digit adders reduces the partial products, so the depth grows with `log2 N` and not with N. When N is not a power of two, a node without a partner is forwarded unchanged to the next level. An optional output register, cleared by synchronous active-high reset, closes the path.

Top module: `msd_modmul`

## Requirements
- R1: A digit is coded {sign, magnitude}: `00` = 0, `01` = +1, `11` = -1. For operands made only of these codes, no digit of `prod_sd` is ever `10`.
- R2: The signed value of `prod_sd` (the sum of digit times 2^position, with position 0 at bits [1:0]) is congruent to value(x) * value(y) modulo 2^N + MU, for MU = -1, 0 and +1 and for any valid operands, including all +1 and all -1 words.
- R3: With REG_OUT = 1, `prod_sd` shows the product of the operands present at the previous rising clock edge and holds its value between edges. While `rst` is high at an edge, `prod_sd` becomes all zeros.
- R4: If either operand is the all-zero vector, `prod_sd` is exactly the all-zero vector.
- R5: If `y_sd` is +1 (digit 0 = `01`, all other digits `00`), the value of the product is congruent to value(x).
- R6: If `y_sd` is -1 (digit 0 = `11`, all other digits `00`), the value of the product is congruent to -value(x). This covers the digit-wise negation path.
- R7: If `y_sd` has a single nonzero digit ±1 at position k, the product is congruent to ±2^k·value(x) modulo m. The wrapped digits carry weight -MU, so with MU = 0 they are dropped.
- R8: The reduction tree is correct when N is not a power of two. For example, with N = 5 and MU = +1, x = 15 and y = 20 give a product congruent to 3 modulo 33.
- R9: With REG_OUT = 0, `prod_sd` follows the operands combinationally and needs no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| x_sd | input | 2*N | Multiplicand, N signed digits |
| y_sd | input | 2*N | Multiplier, N signed digits |
| prod_sd | output | 2*N | Product modulo 2^N+MU, N signed digits |

## Verification
Each operand pair is applied at the same time to three N = 8 instances, one for each MU value. A single mistake in the rotation or in the end-around carry therefore shows up as a mismatch on one modulus only. Single-digit multipliers (+1, -1, ±2^k) isolate the partial-product path: the rotation amount, the -MU scaling of the wrapped digits and the negation. Zero operands check that the result is exactly zero. All-ones, all-minus-ones and random words stress carry chains in every tree level. A five-digit combinational instance checks the forwarding of unpaired nodes and the path with no register.

// File: rtl/msd_pkg.sv
package msd_pkg;

  typedef logic signed [2:0] sval_t;

  localparam logic [1:0] SD_ZERO = 2'b00;
  localparam logic [1:0] SD_POS  = 2'b01;
  localparam logic [1:0] SD_NEG  = 2'b11;

  // two-bit digit code to a small signed integer; an unused code reads as zero
  function automatic sval_t sd_dec(input logic [1:0] d);
    if (!d[0]) return 3'sd0;
    return d[1] ? -3'sd1 : 3'sd1;
  endfunction

  function automatic logic [1:0] sd_enc(input sval_t v);
    if (v < 0) return SD_NEG;
    if (v > 0) return SD_POS;
    return SD_ZERO;
  endfunction

  // negation only toggles the sign of a digit whose magnitude is set
  function automatic logic [1:0] sd_neg(input logic [1:0] d);
    return {d[1] ^ d[0], d[0]};
  endfunction

  // number of nodes on level k of a pairwise reduction of n leaves
  function automatic int lvl_cnt(input int n, input int k);
    return (n + (1 << k) - 1) >> k;
  endfunction

endpackage

// File: rtl/msd_ppgen.sv
module msd_ppgen
  import msd_pkg::*;
#(
  parameter int N  = 8,
  parameter int MU = 1,
  parameter int SH = 0
) (
  input  logic [2*N-1:0] x_sd,
  input  logic [1:0]     y_dig,
  output logic [2*N-1:0] pp_sd
);

  localparam int W = 2 * N;

  logic [W-1:0] rot;

  // end-around rotation by SH digits; wrapped digits take weight -MU
  for (genvar j = 0; j < N; j++) begin : g_rot
    if (j >= SH) begin : g_up
      assign rot[2*j +: 2] = x_sd[2*(j-SH) +: 2];
    end else if (MU == 0) begin : g_drop
      assign rot[2*j +: 2] = SD_ZERO;
    end else if (MU == 1) begin : g_negwrap
      assign rot[2*j +: 2] = sd_neg(x_sd[2*(N-SH+j) +: 2]);
    end else begin : g_keepwrap
      assign rot[2*j +: 2] = x_sd[2*(N-SH+j) +: 2];
    end
  end

  // multiplier digit selects pass, negate or clear
  always_comb begin
    for (int j = 0; j < N; j++) begin
      if (!y_dig[0])     pp_sd[2*j +: 2] = SD_ZERO;
      else if (y_dig[1]) pp_sd[2*j +: 2] = sd_neg(rot[2*j +: 2]);
      else               pp_sd[2*j +: 2] = rot[2*j +: 2];
    end
  end

endmodule

// File: rtl/msd_modadd.sv
module msd_modadd
  import msd_pkg::*;
#(
  parameter int N  = 8,
  parameter int MU = 1
) (
  input  logic [2*N-1:0] a_sd,
  input  logic [2*N-1:0] b_sd,
  output logic [2*N-1:0] s_sd
);

  sval_t pair [N];
  sval_t wsum [N];
  sval_t cout [N];

  // weight of a digit that wraps from position N to position 0
  function automatic sval_t wrap_scale(input sval_t v);
    if (MU == 1)  return -v;
    if (MU == -1) return v;
    return 3'sd0;
  endfunction

  always_comb begin
    sval_t prv;
    sval_t cin;
    for (int i = 0; i < N; i++)
      pair[i] = sd_dec(a_sd[2*i +: 2]) + sd_dec(b_sd[2*i +: 2]);

    // first step: choose interim sum and carry from this and the lower pair
    for (int i = 0; i < N; i++) begin
      if (i == 0) prv = wrap_scale(pair[N-1]);
      else        prv = pair[i-1];
      if (a_sd[2*i] == b_sd[2*i]) begin
        wsum[i] = 3'sd0;
        cout[i] = pair[i] >>> 1;
      end else if ((pair[i] < 0 && prv > 0) || (pair[i] > 0 && prv < 0) ||
                   (prv == 0 && pair[i] < 0)) begin
        wsum[i] = pair[i];
        cout[i] = 3'sd0;
      end else begin
        wsum[i] = -pair[i];
        cout[i] = pair[i];
      end
    end

    // second step: add the incoming carry; this never produces a new carry
    for (int i = 0; i < N; i++) begin
      if (i == 0) cin = wrap_scale(cout[N-1]);
      else        cin = cout[i-1];
      s_sd[2*i +: 2] = sd_enc(wsum[i] + cin);
    end
  end

endmodule

// File: rtl/msd_addtree.sv
module msd_addtree
  import msd_pkg::*;
#(
  parameter int N  = 8,
  parameter int MU = 1
) (
  input  logic [N*2*N-1:0] pp_flat,
  output logic [2*N-1:0]   sum_sd
);

  localparam int W    = 2 * N;
  localparam int LVLS = $clog2(N);

  logic [W-1:0] node [LVLS+1][N];

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign node[0][j] = pp_flat[j*W +: W];
  end

  for (genvar k = 0; k < LVLS; k++) begin : g_lvl
    for (genvar j = 0; j < N; j++) begin : g_node
      if (j < lvl_cnt(N, k+1)) begin : g_used
        if (2*j+1 < lvl_cnt(N, k)) begin : g_add
          msd_modadd #(.N(N), .MU(MU)) u_add (
            .a_sd(node[k][2*j]),
            .b_sd(node[k][2*j+1]),
            .s_sd(node[k+1][j])
          );
        end else begin : g_pass
          assign node[k+1][j] = node[k][2*j];
        end
      end else begin : g_idle
        assign node[k+1][j] = '0;
      end
    end
  end

  assign sum_sd = node[LVLS][0];

endmodule

// File: rtl/msd_modmul.sv
module msd_modmul
  import msd_pkg::*;
#(
  parameter int N       = 8,
  parameter int MU      = 1,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] x_sd,
  input  logic [2*N-1:0] y_sd,
  output logic [2*N-1:0] prod_sd
);

  localparam int W = 2 * N;

  logic [N*W-1:0] pp_flat;
  logic [W-1:0]   sum_sd;

  for (genvar i = 0; i < N; i++) begin : g_pp
    msd_ppgen #(.N(N), .MU(MU), .SH(i)) u_pp (
      .x_sd (x_sd),
      .y_dig(y_sd[2*i +: 2]),
      .pp_sd(pp_flat[i*W +: W])
    );
  end

  msd_addtree #(.N(N), .MU(MU)) u_tree (
    .pp_flat(pp_flat),
    .sum_sd (sum_sd)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] prod_q;
    always_ff @(posedge clk) begin
      if (rst) prod_q <= '0;
      else     prod_q <= sum_sd;
    end
    assign prod_sd = prod_q;
  end else begin : g_comb
    logic unused_ok;
    assign unused_ok = clk ^ rst;
    assign prod_sd   = sum_sd;
  end

endmodule

// File: rtl/msd_modmul_chk.sv
module msd_modmul_chk #(
  parameter int N       = 8,
  parameter int MU      = 1,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic [2*N-1:0] x_sd,
  input logic [2*N-1:0] y_sd,
  input logic [2*N-1:0] prod_sd
);

  localparam longint M = (longint'(1) << N) + MU;

  function automatic longint val(input logic [2*N-1:0] v);
    longint acc = 0;
    for (int i = N-1; i >= 0; i--) begin
      acc = acc * 2;
      if (v[2*i]) acc = v[2*i+1] ? acc - 1 : acc + 1;
    end
    return acc;
  endfunction

  function automatic bit codes_ok(input logic [2*N-1:0] v);
    for (int i = 0; i < N; i++)
      if (v[2*i +: 2] == 2'b10) return 1'b0;
    return 1'b1;
  endfunction

  if (REG_OUT) begin : g_props
    // R3: the cycle after a reset edge shows all zeros
    a_r3_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> prod_sd == '0);

    // R1: valid operand codes give valid product codes
    a_r1_digit_codes: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && codes_ok($past(x_sd)) && codes_ok($past(y_sd)))
        |-> codes_ok(prod_sd));

    // R2: product congruent to the operands of the previous edge
    a_r2_congruent: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |->
        ((val(prod_sd) - val($past(x_sd)) * val($past(y_sd))) % M) == 0);

    // R4: a zero operand forces an exactly zero result
    a_r4_zero_operand: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(x_sd) == '0 || $past(y_sd) == '0))
        |-> prod_sd == '0);
  end else begin : g_noprops
    logic unused_ok;
    assign unused_ok = clk ^ rst ^ (^x_sd) ^ (^y_sd) ^ (^prod_sd);
  end

endmodule

bind msd_modmul msd_modmul_chk #(.N(N), .MU(MU), .REG_OUT(REG_OUT)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .x_sd   (x_sd),
  .y_sd   (y_sd),
  .prod_sd(prod_sd)
);

// File: tb/msd_modmul_test.sv
`timescale 1ns/1ps
module msd_modmul_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] x8 = '0, y8 = '0;
  logic [9:0]  x5 = '0, y5 = '0;
  logic [15:0] p_p1, p_z, p_m1;
  logic [9:0]  p5;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  msd_modmul #(.N(8), .MU(1),  .REG_OUT(1)) uut   (.clk(clk), .rst(rst), .x_sd(x8), .y_sd(y8), .prod_sd(p_p1));
  msd_modmul #(.N(8), .MU(0),  .REG_OUT(1)) uut_z (.clk(clk), .rst(rst), .x_sd(x8), .y_sd(y8), .prod_sd(p_z));
  msd_modmul #(.N(8), .MU(-1), .REG_OUT(1)) uut_m (.clk(clk), .rst(rst), .x_sd(x8), .y_sd(y8), .prod_sd(p_m1));
  msd_modmul #(.N(5), .MU(1),  .REG_OUT(0)) uut_5 (.clk(clk), .rst(rst), .x_sd(x5), .y_sd(y5), .prod_sd(p5));

  function automatic longint sdval(input logic [63:0] v, input int n);
    longint acc = 0;
    for (int i = n-1; i >= 0; i--) begin
      acc = acc * 2;
      if (v[2*i +: 2] == 2'b01) acc = acc + 1;
      else if (v[2*i +: 2] == 2'b11) acc = acc - 1;
    end
    return acc;
  endfunction

  function automatic bit codes_ok(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++)
      if (v[2*i +: 2] == 2'b10) return 1'b0;
    return 1'b1;
  endfunction

  function automatic longint nmod(input longint a, input longint m);
    longint r = a % m;
    if (r < 0) r = r + m;
    return r;
  endfunction

  function automatic logic [15:0] rnd8();
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      case ($urandom % 3)
        0: v[2*i +: 2] = 2'b00;
        1: v[2*i +: 2] = 2'b01;
        default: v[2*i +: 2] = 2'b11;
      endcase
    end
    return v;
  endfunction

  function automatic logic [9:0] rnd5();
    logic [15:0] t = rnd8();
    return t[9:0];
  endfunction

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_res(input string tag, input logic [63:0] p, input int n,
                         input longint m, input longint want);
    longint a = nmod(sdval(p, n), m);
    longint e = nmod(want, m);
    chk({tag, " R1 codes"}, codes_ok(p, n), sdval(p, n), e);
    chk(tag, a == e, a, e);
  endtask

  // checks the three N=8 instances against a wanted value
  task automatic chk8(input string tag, input longint want);
    chk_res({tag, " mu+1"}, 64'(p_p1), 8, 257, want);
    chk_res({tag, " mu0"},  64'(p_z),  8, 256, want);
    chk_res({tag, " mu-1"}, 64'(p_m1), 8, 255, want);
  endtask

  task automatic apply8(input logic [15:0] xv, input logic [15:0] yv);
    @(negedge clk);
    x8 = xv;
    y8 = yv;
    @(negedge clk);
  endtask

  task automatic t_reset();
    x8 = rnd8(); y8 = rnd8();
    repeat (3) @(negedge clk);
    chk("R3 reset mu+1", p_p1 == '0, sdval(64'(p_p1), 8), 0);
    chk("R3 reset mu0",  p_z  == '0, sdval(64'(p_z), 8), 0);
    chk("R3 reset mu-1", p_m1 == '0, sdval(64'(p_m1), 8), 0);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    logic [15:0] xa = 16'h0145, ya = 16'h0d01;
    logic [15:0] xb = rnd8(), yb = rnd8();
    apply8(xa, ya);
    x8 = xb; y8 = yb;
    #1;
    chk8("R3 hold before edge", sdval(64'(xa), 8) * sdval(64'(ya), 8));
    @(negedge clk);
    chk8("R3 update after edge", sdval(64'(xb), 8) * sdval(64'(yb), 8));
  endtask

  task automatic t_zero();
    for (int k = 0; k < 4; k++) begin
      logic [15:0] r = rnd8();
      apply8(16'h0000, r);
      chk("R4 zero x mu+1", p_p1 == '0, sdval(64'(p_p1), 8), 0);
      chk("R4 zero x mu-1", p_m1 == '0, sdval(64'(p_m1), 8), 0);
      apply8(r, 16'h0000);
      chk("R4 zero y mu0",  p_z == '0, sdval(64'(p_z), 8), 0);
      chk("R4 zero y mu+1", p_p1 == '0, sdval(64'(p_p1), 8), 0);
    end
  endtask

  task automatic t_unit();
    for (int k = 0; k < 6; k++) begin
      logic [15:0] r = rnd8();
      apply8(r, 16'h0001);
      chk8("R5 times one", sdval(64'(r), 8));
      apply8(r, 16'h0003);
      chk8("R6 times minus one", -sdval(64'(r), 8));
    end
  endtask

  task automatic t_shift();
    for (int k = 0; k < 8; k++) begin
      logic [15:0] r = rnd8();
      logic [15:0] yp = 16'h0001 << (2*k);
      logic [15:0] yn = 16'h0003 << (2*k);
      apply8(r, yp);
      chk8("R7 shift pos", sdval(64'(r), 8) << k);
      apply8(r, yn);
      chk8("R7 shift neg", -(sdval(64'(r), 8) << k));
    end
  endtask

  task automatic t_extremes();
    apply8(16'h5555, 16'h5555);
    chk8("R2 all plus", 255 * 255);
    apply8(16'hffff, 16'hffff);
    chk8("R2 all minus", 255 * 255);
    apply8(16'h5555, 16'hffff);
    chk8("R2 plus by minus", -(255 * 255));
    apply8(16'h7777, 16'hdddd);
    chk8("R2 alternating", sdval(64'h7777, 8) * sdval(64'hdddd, 8));
  endtask

  task automatic t_random();
    for (int k = 0; k < 300; k++) begin
      logic [15:0] xr = rnd8(), yr = rnd8();
      apply8(xr, yr);
      chk8("R2 random", sdval(64'(xr), 8) * sdval(64'(yr), 8));
    end
  endtask

  task automatic t_odd_width();
    @(negedge clk);
    x5 = 10'b01_00_11_01_01;
    y5 = 10'b01_01_11_00_00;
    #1;
    chk_res("R8 five digit example", 64'(p5), 5, 33, 3);
    for (int k = 0; k < 100; k++) begin
      logic [9:0] xr = rnd5(), yr = rnd5();
      x5 = xr; y5 = yr;
      #1;
      chk_res("R9 combinational five digit", 64'(p5), 5, 33,
              sdval(64'(xr), 5) * sdval(64'(yr), 5));
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_zero();
    t_unit();
    t_shift();
    t_extremes();
    t_random();
    t_odd_width();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule